// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the control strobes that an 8-bit microcontroller core drives onto its external memory bus. It divides the oscillator clock into machine cycles of six states, each state holding two phases. Every machine cycle is either a program fetch or an external data transfer. From the cycle type it drives the address latch strobe (`ale`), the active-low program-store enable (`psen_n`) and the active-low read and write strobes (`rd_n`, `wr_n`). It also reports on `fetch_ext` whether the current fetch goes to external memory. A fetch goes to external memory when the external-access pin `ea_pin` is low, or when the program counter is at or above the upper half of the address space. A double-speed select halves the machine cycle.

A data transfer is requested with a valid/ready handshake. The core raises `dreq_valid` together with `dreq_we`. It must hold both until `dreq_ready` is seen high on a clock edge. `dreq_ready` is high only in the last clock of a machine cycle, so the sequencer pushes back on a request for up to one full machine cycle. The request is taken on that edge and the next machine cycle becomes the data cycle.

The block also qualifies the raw reset pin. `core_rst` rises only after the pin has been sampled high for two whole machine cycles. While `core_rst` is high the sequencer stays idle.

Top module: `ext_strobe_seq`

## Requirements
- R1: A machine cycle lasts 12 clocks in normal mode and 6 clocks in double-speed mode. `x2_mode` is sampled only on the edge that starts a machine cycle.
- R2: In a fetch cycle `ale` is high in state 1 and again in state 4. In normal mode this is clocks 0–1 and 6–7; in double-speed mode it is clocks 0 and 3. This gives two pulses per cycle: one sixth of the clock rate in normal mode and one third in double-speed mode.
- R3: In a fetch that goes to external memory, `psen_n` is low in states 2–3 and 5–6, which gives two pulses per cycle. `psen_n` stays high for the whole of an internal fetch and the whole of a data cycle.
- R4: A fetch is external when `ea_pin` is 0 or `pc` is at least 16'h8000; otherwise it is internal. `fetch_ext` shows this for the whole fetch cycle and is 0 in data cycles.
- R5: `ale_off`=1 removes both `ale` pulses from internal fetches. It has no effect on external fetches.
- R6: In a data cycle `ale` stays low. Exactly one strobe is low in states 2–5: `rd_n` when `dreq_we`=0, or `wr_n` when `dreq_we`=1. `rd_n` and `wr_n` are never low together.
- R7: `dreq_ready` is high only in the last clock of a machine cycle, and only while `core_rst` is low. A request is taken when `dreq_valid` and `dreq_ready` are both high.
- R8: `core_rst` rises after `rst_pin` has been sampled high on 24 consecutive edges in normal mode, or 12 in double-speed mode. Fewer consecutive samples do nothing. `core_rst` falls on the first edge that samples `rst_pin` low.
- R9: While `rst_n` is low, or from the second edge of `core_rst`, the strobes are idle: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `dreq_ready`=0. After `core_rst` falls, the next edge starts a new machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw reset pin level, active high |
| x2_mode | input | 1 | Double-speed machine cycle select |
| ale_off | input | 1 | Suppress `ale` on internal fetches |
| ea_pin | input | 1 | External-access pin level |
| pc | input | ADDR_W | Program counter of the next fetch |
| dreq_valid | input | 1 | Data transfer request valid |
| dreq_we | input | 1 | Request direction, 1 = write |
| dreq_ready | output | 1 | Request accepted on this edge |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| fetch_ext | output | 1 | Current fetch is served externally |
| core_rst | output | 1 | Qualified reset to the core |

## Verification
The hardest case to reach from the ports is the reset qualifier's threshold. It depends on the mode latched at the last cycle start, while the sequencer keeps running underneath. The stimulus first lets a double-speed cycle latch the mode. It then holds `rst_pin` high for exactly one edge short of the threshold, drops the pin, and raises it again for the full count. This is done in both modes, and each time the bench then restarts the sequencer and checks one complete cycle.

// File: rtl/esq_pkg.sv
package esq_pkg;
  localparam int STATES = 6;
  localparam int SLOTS  = 2 * STATES;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ST_W   = SLOT_W - 1;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [ST_W-1:0]   state_t;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_RD    = 2'd2,
    CYC_WR    = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      ext;
    logic      ale_en;
  } cyc_attr_t;
endpackage

// File: rtl/esq_rst_qual.sv
module esq_rst_qual
  import esq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic x2_q,
  output logic core_rst
);
  localparam int CNT_W = $clog2(2 * SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(2 * SLOTS);
  localparam logic [CNT_W-1:0] LIM_NORM = CNT_W'(2 * SLOTS - 1);
  localparam logic [CNT_W-1:0] LIM_X2   = CNT_W'(2 * STATES - 1);

  logic [CNT_W-1:0] high_cnt;
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1 = x2_q ? LIM_X2 : LIM_NORM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_cnt <= '0;
      core_rst <= 1'b1;
    end else begin
      if (!pin) high_cnt <= '0;
      else if (high_cnt != CNT_MAX) high_cnt <= high_cnt + 1'b1;
      core_rst <= pin && (core_rst || (high_cnt >= lim_m1));
    end
  end
endmodule

// File: rtl/esq_timer.sv
module esq_timer
  import esq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  x2_in,
  output slot_t slot,
  output logic  x2_q,
  output logic  wrap
);
  localparam slot_t LAST      = slot_t'(SLOTS - 1);
  localparam slot_t LAST_X2   = slot_t'(SLOTS - 2);
  localparam slot_t STEP_NORM = slot_t'(1);
  localparam slot_t STEP_X2   = slot_t'(2);

  assign wrap = x2_q ? (slot >= LAST_X2) : (slot == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= LAST;
      x2_q <= 1'b0;
    end else if (hold) begin
      slot <= LAST;
      x2_q <= x2_in;
    end else if (wrap) begin
      slot <= '0;
      x2_q <= x2_in;
    end else begin
      slot <= slot + (x2_q ? STEP_X2 : STEP_NORM);
    end
  end
endmodule

// File: rtl/esq_decode.sv
module esq_decode
  import esq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  wrap,
  input  slot_t slot,
  input  logic  take_data,
  input  logic  data_we,
  input  logic  go_ext,
  input  logic  ale_en,
  output logic  ale,
  output logic  psen_n,
  output logic  rd_n,
  output logic  wr_n,
  output logic  fetch_ext
);
  localparam state_t ST_ALE_A = state_t'(0);
  localparam state_t ST_ALE_B = state_t'(STATES / 2);
  localparam state_t ST_XF_LO = state_t'(1);
  localparam state_t ST_XF_HI = state_t'(STATES - 2);

  cyc_attr_t cur;
  state_t    st;
  logic      ale_state;
  logic      xfer_state;

  assign st         = slot[SLOT_W-1:1];
  assign ale_state  = (st == ST_ALE_A) || (st == ST_ALE_B);
  assign xfer_state = (st >= ST_XF_LO) && (st <= ST_XF_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '{kind: CYC_IDLE, ext: 1'b0, ale_en: 1'b0};
    end else if (hold) begin
      cur <= '{kind: CYC_IDLE, ext: 1'b0, ale_en: 1'b0};
    end else if (wrap) begin
      cur.kind   <= take_data ? (data_we ? CYC_WR : CYC_RD) : CYC_FETCH;
      cur.ext    <= go_ext;
      cur.ale_en <= ale_en;
    end
  end

  always_comb begin
    ale       = 1'b0;
    psen_n    = 1'b1;
    rd_n      = 1'b1;
    wr_n      = 1'b1;
    fetch_ext = 1'b0;
    unique case (cur.kind)
      CYC_FETCH: begin
        ale       = ale_state && cur.ale_en;
        psen_n    = !(cur.ext && !ale_state);
        fetch_ext = cur.ext;
      end
      CYC_RD:  rd_n = !xfer_state;
      CYC_WR:  wr_n = !xfer_state;
      default: ;
    endcase
  end
endmodule

// File: rtl/ext_strobe_seq.sv
module ext_strobe_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              x2_mode,
  input  logic              ale_off,
  input  logic              ea_pin,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dreq_valid,
  input  logic              dreq_we,
  output logic              dreq_ready,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              fetch_ext,
  output logic              core_rst
);
  import esq_pkg::*;

  localparam logic [ADDR_W-1:0] EXT_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

  slot_t slot;
  logic  x2_q;
  logic  wrap;
  logic  go_ext;
  logic  take_data;

  esq_rst_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (rst_pin),
    .x2_q     (x2_q),
    .core_rst (core_rst)
  );

  esq_timer u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (core_rst),
    .x2_in (x2_mode),
    .slot  (slot),
    .x2_q  (x2_q),
    .wrap  (wrap)
  );

  assign go_ext     = !ea_pin || (pc >= EXT_BASE);
  assign dreq_ready = wrap && !core_rst;
  assign take_data  = dreq_valid && dreq_ready;

  esq_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (core_rst),
    .wrap      (wrap),
    .slot      (slot),
    .take_data (take_data),
    .data_we   (dreq_we),
    .go_ext    (go_ext),
    .ale_en    (go_ext || !ale_off),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .fetch_ext (fetch_ext)
  );
endmodule

// File: rtl/esq_checker.sv
module esq_checker (
  input logic clk,
  input logic rst_n,
  input logic rst_pin,
  input logic dreq_ready,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic fetch_ext,
  input logic core_rst
);
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r3_no_psen_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> psen_n);

  a_r6_no_ale_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (!ale && !fetch_ext));

  a_r3_psen_only_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> fetch_ext);

  a_r7_no_ready_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !dreq_ready);

  a_r9_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && $past(core_rst)) |-> (!ale && psen_n && rd_n && wr_n));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin |=> !core_rst);
endmodule

bind ext_strobe_seq esq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_pin    (rst_pin),
  .dreq_ready (dreq_ready),
  .ale        (ale),
  .psen_n     (psen_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .fetch_ext  (fetch_ext),
  .core_rst   (core_rst)
);

// File: tb/ext_strobe_seq_tb_top.sv
module ext_strobe_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, rst_pin, x2_mode, ale_off, ea_pin, dreq_valid, dreq_we;
  logic [15:0] pc;
  logic        dreq_ready, ale, psen_n, rd_n, wr_n, fetch_ext, core_rst;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  ext_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .x2_mode(x2_mode),
    .ale_off(ale_off), .ea_pin(ea_pin), .pc(pc), .dreq_valid(dreq_valid),
    .dreq_we(dreq_we), .dreq_ready(dreq_ready), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .fetch_ext(fetch_ext), .core_rst(core_rst)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // vector order: {dreq_ready, ale, psen_n, rd_n, wr_n, fetch_ext}
  function automatic logic [5:0] expect_vec(input int k, input int n, input bit x2,
      input int kind, input bit ext, input bit aoff);
    int   st;
    logic a, p, r, w, f;
    bit   ale_st;
    st     = x2 ? k : k / 2;
    ale_st = (st == 0) || (st == 3);
    a = 1'b0; p = 1'b1; r = 1'b1; w = 1'b1; f = 1'b0;
    if (kind == 0) begin
      a = ale_st && (ext || !aoff);
      p = !(ext && !ale_st);
      f = ext;
    end else if (kind == 1) begin
      r = !(st >= 1 && st <= 4);
    end else begin
      w = !(st >= 1 && st <= 4);
    end
    return {(k == n - 1), a, p, r, w, f};
  endfunction

  // called at the falling edge inside the last clock of a machine cycle
  task automatic drive_cycle(input bit x2, input int kind, input bit ea,
      input logic [15:0] pcv, input bit aoff, input string tag);
    int n;
    bit ext;
    n   = x2 ? 6 : 12;
    ext = !ea || (pcv >= 16'h8000);
    check(dreq_ready == 1'b1, "R7 ready at cycle end", 16'(dreq_ready), 16'd1);
    x2_mode    = x2;
    ea_pin     = ea;
    pc         = pcv;
    ale_off    = aoff;
    dreq_valid = (kind != 0);
    dreq_we    = (kind == 2);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(expect_vec(k, n, x2, kind, (kind == 0) && ext, aoff));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    check(dreq_ready == 1'b0, "R7 ready low mid-cycle", 16'(dreq_ready), 16'd0);
    dreq_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      logic [5:0] a;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {dreq_ready, ale, psen_n, rd_n, wr_n, fetch_ext};
      check(a == e, t, 16'(a), 16'(e));
    end
  end

  task automatic check_idle(input string tag);
    check({ale, psen_n, rd_n, wr_n, dreq_ready} == 5'b01110, tag,
          16'({ale, psen_n, rd_n, wr_n, dreq_ready}), 16'b01110);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; rst_pin = 1; x2_mode = 0; ale_off = 0; ea_pin = 1;
    pc = '0; dreq_valid = 0; dreq_we = 0;
    repeat (3) @(negedge clk);
    check(core_rst == 1'b1, "R9 core_rst in power-on reset", 16'(core_rst), 16'd1);
    check_idle("R9 idle in power-on reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(core_rst == 1'b1, "R8 pin still high", 16'(core_rst), 16'd1);
    rst_pin = 0;
    @(negedge clk);
    check(core_rst == 1'b0, "R8 release after one edge", 16'(core_rst), 16'd0);

    drive_cycle(0, 0, 1, 16'h0100, 0, "R1 R2 R3 R4 internal fetch");
    drive_cycle(0, 0, 1, 16'h8000, 0, "R3 R4 boundary external fetch");
    drive_cycle(0, 0, 0, 16'h0010, 0, "R4 ea low external fetch");
    drive_cycle(0, 0, 1, 16'h1234, 1, "R5 ale_off internal fetch");
    drive_cycle(0, 0, 1, 16'h9000, 1, "R5 ale_off ignored external");
    drive_cycle(0, 1, 1, 16'h0200, 0, "R6 data read");
    drive_cycle(0, 2, 1, 16'h0200, 0, "R6 data write");
    drive_cycle(1, 0, 0, 16'h0040, 0, "R1 R2 R3 double-speed ext fetch");
    drive_cycle(1, 0, 1, 16'h0040, 0, "R1 R2 double-speed int fetch");
    drive_cycle(1, 2, 1, 16'h0040, 0, "R6 double-speed write");
    drive_cycle(0, 0, 1, 16'h7FFF, 0, "R4 last internal address");

    // normal-mode qualifier threshold
    rst_pin = 1;
    repeat (23) @(negedge clk);
    check(core_rst == 1'b0, "R8 23 edges normal no reset", 16'(core_rst), 16'd0);
    rst_pin = 0;
    @(negedge clk);
    rst_pin = 1;
    repeat (24) @(negedge clk);
    check(core_rst == 1'b1, "R8 24 edges normal reset", 16'(core_rst), 16'd1);
    repeat (3) @(negedge clk);
    check_idle("R9 idle under qualified reset");
    rst_pin = 0;
    @(negedge clk);
    check(core_rst == 1'b0, "R8 release normal", 16'(core_rst), 16'd0);
    drive_cycle(1, 1, 1, 16'h0300, 0, "R9 restart double-speed read");

    // double-speed qualifier threshold
    rst_pin = 1;
    repeat (11) @(negedge clk);
    check(core_rst == 1'b0, "R8 11 edges x2 no reset", 16'(core_rst), 16'd0);
    rst_pin = 0;
    @(negedge clk);
    rst_pin = 1;
    repeat (12) @(negedge clk);
    check(core_rst == 1'b1, "R8 12 edges x2 reset", 16'(core_rst), 16'd1);
    rst_pin = 0;
    @(negedge clk);
    check(core_rst == 1'b0, "R8 release x2", 16'(core_rst), 16'd0);
    drive_cycle(0, 0, 0, 16'h0500, 0, "R9 restart normal fetch");
    @(negedge clk);
    finish_run();
  end
endmodule